// File: doc/BRIEF.md
# EEPROM Page Write Controller

This block sits behind a serial-bus slave engine in an EEPROM model and turns one write transaction into a timed programming cycle. The engine opens a transaction with a start pulse that carries a 9-bit byte address. It then streams the data bytes over a valid/ready channel and closes the transaction with a stop pulse. Received bytes are collected in a 16-byte staging buffer that covers the aligned page holding the start address. A per-byte mask records which locations were actually received. Each accepted byte gets an acknowledge verdict one cycle later, which the engine turns into the bit it drives on the bus.

Nothing reaches the 512-byte array until stop. A stop after one or more whole bytes starts a self-timed write cycle that holds `busy` high for `WR_CYCLES` clocks. The default is 6 ms at 200 MHz. During that window, only the masked bytes of the page are copied into the array. When the window closes, the address counter shared with the read path points just past the last byte written, wrapped within the page.

When `write_lock` is high, the upper 256 bytes are protected. Data bytes aimed at that half are refused, and the transaction is cancelled. A synchronous read port, with one cycle of latency, exposes the array to the read path.

Stream rules: a byte transfers on a clock edge where both `wr_valid` and `wr_ready` are high. `wr_ready` is high only while a transaction is open, and it drops in any cycle that carries `txn_start` or `txn_stop`. The engine may hold `wr_valid` with its data for as long as `wr_ready` stays low. No byte is lost or taken twice.

Top module: `eeprom_page_writer`

## Requirements
- R1: `wr_ready` is high only after an accepted `txn_start` and before the next `txn_stop`, and never in a cycle carrying `txn_start` or `txn_stop`. A `txn_start` that arrives while `busy` is high is ignored and opens no transaction.
- R2: For each byte transferred at a clock edge, `ack_valid` is high for exactly the following cycle. `ack_valid` is low in every other cycle.
- R3: Bytes are stored starting at the slot given by address bits [3:0] of the start address. After each stored byte, only those four bits advance, modulo 16, while bits [8:4] stay fixed. A seventeenth byte therefore overwrites the first one.
- R4: A write cycle updates only the locations of the page that received a byte. The other bytes of the page keep their previous contents.
- R5: The array is not changed before `txn_stop`. A read issued while a transaction is open returns the old contents.
- R6: A committing `txn_stop` raises `busy` on the next cycle. `busy` then stays high for exactly `WR_CYCLES` cycles.
- R7: While `write_lock` is high, a byte sent to a transaction whose start address has bit 8 set gets `ack_ok`=0 and is not stored. A transaction holding any refused byte starts no write cycle on stop.
- R8: A byte that R7 does not refuse gets `ack_ok`=1. With `write_lock` low, all 512 bytes are writable. With `write_lock` high, the lower 256 bytes stay writable.
- R9: A `txn_stop` with no stored byte, or with `stop_partial` high, leaves `busy` low and the array unchanged.
- R10: `addr_ptr` resets to 0 and changes only as `busy` falls. At that point it becomes the page base plus ((last stored slot + 1) mod 16).
- R11: `rd_data` shows the array byte at `rd_addr` one cycle after `rd_en`.
- R12: After reset, `busy`, `wr_ready` and `ack_valid` are low and `addr_ptr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Opens a write transaction at `txn_addr` |
| txn_addr | input | 9 | Start byte address of the transaction |
| wr_valid | input | 1 | Data byte offered |
| wr_ready | output | 1 | Data byte can be taken this cycle |
| wr_data | input | 8 | Data byte |
| ack_valid | output | 1 | Verdict for the byte taken one cycle earlier |
| ack_ok | output | 1 | 1 = byte acknowledged, 0 = refused |
| txn_stop | input | 1 | Ends the open transaction |
| stop_partial | input | 1 | Stop came with an incomplete byte pending |
| write_lock | input | 1 | Protects the upper 256 bytes when high |
| busy | output | 1 | Internal write cycle in progress |
| addr_ptr | output | 9 | Address counter handed to the read path |
| rd_en | input | 1 | Read request |
| rd_addr | input | 9 | Read address |
| rd_data | output | 8 | Read data, one cycle after `rd_en` |

## Verification
The bench builds the block with `WR_CYCLES` set to 40 instead of the 6 ms default. A full write cycle then takes a few dozen clocks. This lets one run cover byte writes, page wrap with overwrite, partial pages, protected and unprotected halves, empty and torn stops, and starts sent into a busy window. Addresses and data widths keep their defaults, so the upper-half protection and the 16-byte page arithmetic are exercised exactly as built.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PROG = 2'd2
  } eepw_state_t;

endpackage

// File: rtl/eepw_page_buf.sv
// Staging buffer for one page: byte slots, received mask, wrapping slot pointer.
module eepw_page_buf #(
  parameter int DATA_W = 8,
  parameter int SLOT_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic [SLOT_W-1:0]        first_slot,
  input  logic                     wr_en,
  input  logic [DATA_W-1:0]        wr_byte,
  input  logic [SLOT_W-1:0]        rd_slot,
  output logic [DATA_W-1:0]        rd_byte,
  output logic [(1<<SLOT_W)-1:0]   mask,
  output logic [SLOT_W-1:0]        last_slot
);

  localparam int NSLOT = 1 << SLOT_W;

  logic [NSLOT-1:0][DATA_W-1:0] slot_q;
  logic [NSLOT-1:0]             mask_q;
  logic [NSLOT-1:0]             hit;
  logic [SLOT_W-1:0]            ptr_q;
  logic [SLOT_W-1:0]            last_q;

  // One decoded write strobe per slot.
  for (genvar i = 0; i < NSLOT; i++) begin : g_hit
    assign hit[i] = wr_en && (ptr_q == SLOT_W'(i));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSLOT; i++) begin
      if (hit[i]) slot_q[i] <= wr_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      ptr_q  <= '0;
      last_q <= '0;
    end else if (clear) begin
      mask_q <= '0;
      ptr_q  <= first_slot;
      last_q <= first_slot;
    end else if (wr_en) begin
      mask_q <= mask_q | hit;
      last_q <= ptr_q;
      ptr_q  <= ptr_q + SLOT_W'(1);  // wraps inside the page
    end
  end

  assign rd_byte   = slot_q[rd_slot];
  assign mask      = mask_q;
  assign last_slot = last_q;

endmodule

// File: rtl/eepw_prog_timer.sv
// Self-timed programming window of a fixed number of cycles.
module eepw_prog_timer #(
  parameter int CYCLES = 1200000,
  localparam int CW    = $clog2(CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick,
  output logic          busy,
  output logic [CW-1:0] count,
  output logic          done
);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign done = busy_q && (cnt_q == CW'(CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (kick) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (done) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign busy  = busy_q;
  assign count = cnt_q;

endmodule

// File: rtl/eepw_array.sv
// Byte array: one write port, one registered read port.
module eepw_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eepw_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 1200000   // must exceed 1 << PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ack_valid,
  output logic              ack_ok,
  input  logic              txn_stop,
  input  logic              stop_partial,
  input  logic              write_lock,
  output logic              busy,
  output logic [ADDR_W-1:0] addr_ptr,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int BLK_W      = ADDR_W - PAGE_W;
  localparam int CW         = $clog2(WR_CYCLES + 1);

  eepw_state_t state_q;
  logic [BLK_W-1:0]      page_q;
  logic                  refused_q;
  logic                  ack_v_q, ack_ok_q;
  logic [ADDR_W-1:0]     ptr_q;

  logic                  open_new, take, locked, store, commit;
  logic                  prog_busy, prog_done;
  logic [CW-1:0]         prog_cnt;
  logic [PAGE_W-1:0]     copy_slot, last_slot;
  logic [PAGE_BYTES-1:0] rx_mask;
  logic [DATA_W-1:0]     copy_byte;
  logic                  arr_we;

  // Transaction control.
  assign open_new = txn_start && (state_q != ST_PROG);
  assign wr_ready = (state_q == ST_FILL) && !txn_start && !txn_stop;
  assign take     = wr_valid && wr_ready;
  assign locked   = write_lock && page_q[BLK_W-1];
  assign store    = take && !locked;
  assign commit   = (state_q == ST_FILL) && txn_stop && !txn_start &&
                    !stop_partial && (|rx_mask) && !refused_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      page_q    <= '0;
      refused_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (open_new) begin
            state_q   <= ST_FILL;
            page_q    <= txn_addr[ADDR_W-1:PAGE_W];
            refused_q <= 1'b0;
          end
        end
        ST_FILL: begin
          if (open_new) begin
            page_q    <= txn_addr[ADDR_W-1:PAGE_W];
            refused_q <= 1'b0;
          end else if (txn_stop) begin
            state_q <= commit ? ST_PROG : ST_IDLE;
          end else if (take && locked) begin
            refused_q <= 1'b1;
          end
        end
        ST_PROG: begin
          if (prog_done) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Per-byte verdict, one cycle after the transfer.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_v_q  <= 1'b0;
      ack_ok_q <= 1'b0;
    end else begin
      ack_v_q  <= take;
      ack_ok_q <= store;
    end
  end

  assign ack_valid = ack_v_q;
  assign ack_ok    = ack_ok_q;

  eepw_page_buf #(
    .DATA_W (DATA_W),
    .SLOT_W (PAGE_W)
  ) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (open_new),
    .first_slot (txn_addr[PAGE_W-1:0]),
    .wr_en      (store),
    .wr_byte    (wr_data),
    .rd_slot    (copy_slot),
    .rd_byte    (copy_byte),
    .mask       (rx_mask),
    .last_slot  (last_slot)
  );

  eepw_prog_timer #(
    .CYCLES (WR_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .kick  (commit),
    .busy  (prog_busy),
    .count (prog_cnt),
    .done  (prog_done)
  );

  // Copy masked slots into the array during the first page-size cycles.
  assign copy_slot = prog_cnt[PAGE_W-1:0];
  assign arr_we    = prog_busy && (prog_cnt < CW'(PAGE_BYTES)) && rx_mask[copy_slot];

  eepw_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk   (clk),
    .we    (arr_we),
    .waddr ({page_q, copy_slot}),
    .wdata (copy_byte),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // Shared address counter, moved once the cycle completes.
  always_ff @(posedge clk) begin
    if (!rst_n)         ptr_q <= '0;
    else if (prog_done) ptr_q <= {page_q, last_slot + PAGE_W'(1)};
  end

  assign addr_ptr = ptr_q;
  assign busy     = prog_busy;

endmodule

// File: rtl/eepw_checker.sv
module eepw_checker #(
  parameter int ADDR_W    = 9,
  parameter int WR_CYCLES = 1200000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txn_start,
  input logic [ADDR_W-1:0] txn_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              ack_valid,
  input logic              ack_ok,
  input logic              txn_stop,
  input logic              stop_partial,
  input logic              write_lock,
  input logic              busy,
  input logic [ADDR_W-1:0] addr_ptr
);

  logic [31:0] busy_len;
  logic        hi_half;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 32'd1;
    else           busy_len <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 hi_half <= 1'b0;
    else if (txn_start && !busy) hi_half <= txn_addr[ADDR_W-1];
  end

  assert_busy_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready);

  assert_ack_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> ack_valid);

  assert_no_spurious_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> !ack_valid);

  assert_busy_from_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(txn_stop));

  assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == 32'(WR_CYCLES)));

  assert_locked_nack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && write_lock && hi_half) |=> (ack_valid && !ack_ok));

  assert_open_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !(write_lock && hi_half)) |=> ack_ok);

  assert_torn_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_stop && stop_partial && !busy) |=> !busy);

  assert_ptr_moves_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_ptr) |-> $fell(busy));

endmodule

bind eeprom_page_writer eepw_checker #(
  .ADDR_W    (ADDR_W),
  .WR_CYCLES (WR_CYCLES)
) u_eepw_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .txn_start    (txn_start),
  .txn_addr     (txn_addr),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .ack_valid    (ack_valid),
  .ack_ok       (ack_ok),
  .txn_stop     (txn_stop),
  .stop_partial (stop_partial),
  .write_lock   (write_lock),
  .busy         (busy),
  .addr_ptr     (addr_ptr)
);

// File: tb/test_eeprom_page_writer.sv
`timescale 1ns/1ps
module test_eeprom_page_writer;

  localparam int AW = 9;
  localparam int DW = 8;
  localparam int WR = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          txn_start = 1'b0;
  logic [AW-1:0] txn_addr = '0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic          ack_valid, ack_ok;
  logic          txn_stop = 1'b0;
  logic          stop_partial = 1'b0;
  logic          write_lock = 1'b0;
  logic          busy;
  logic [AW-1:0] addr_ptr;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;

  always #2.5 clk = ~clk;

  eeprom_page_writer #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(4), .WR_CYCLES(WR)) i_eeprom_page_writer (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_addr(txn_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .ack_valid(ack_valid), .ack_ok(ack_ok), .txn_stop(txn_stop),
    .stop_partial(stop_partial), .write_lock(write_lock), .busy(busy),
    .addr_ptr(addr_ptr), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_state, m_page, m_slot, m_last, m_cnt, m_ptr, m_rd;
  bit m_blk, m_ackv, m_ackok, m_rdchk;
  int m_buf [16];
  bit m_msk [16];
  int m_mem [512];
  bit m_known [512];

  function automatic bit any_mask();
    for (int i = 0; i < 16; i++) if (m_msk[i]) return 1;
    return 0;
  endfunction

  task automatic m_open(input int a);
    m_state = 1; m_page = a & 'h1F0; m_slot = a & 'hF; m_last = m_slot; m_blk = 0;
    for (int i = 0; i < 16; i++) m_msk[i] = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_ptr = 0; m_ackv = 0; m_ackok = 0; m_rdchk = 0; m_cnt = 0;
      m_blk = 0; m_page = 0; m_slot = 0; m_last = 0; m_rd = 0;
      for (int i = 0; i < 16; i++) begin m_msk[i] = 0; m_buf[i] = 0; end
      for (int i = 0; i < 512; i++) begin m_mem[i] = 0; m_known[i] = 0; end
    end else begin
      m_ackv = 0;
      m_rdchk = rd_en && (m_state != 2) && m_known[rd_addr];
      if (rd_en) m_rd = m_mem[rd_addr];
      case (m_state)
        0: if (txn_start) m_open(int'(txn_addr));
        1: begin
          if (txn_start) m_open(int'(txn_addr));
          else if (txn_stop) begin
            if (!stop_partial && any_mask() && !m_blk) begin m_state = 2; m_cnt = 0; end
            else m_state = 0;
          end else if (wr_valid) begin
            m_ackv = 1;
            if (write_lock && m_page >= 256) begin m_ackok = 0; m_blk = 1; end
            else begin
              m_ackok = 1; m_buf[m_slot] = int'(wr_data); m_msk[m_slot] = 1;
              m_last = m_slot; m_slot = (m_slot + 1) % 16;
            end
          end
        end
        default: begin
          if (m_cnt == WR - 1) begin
            for (int i = 0; i < 16; i++)
              if (m_msk[i]) begin m_mem[m_page + i] = m_buf[i]; m_known[m_page + i] = 1; end
            m_ptr = m_page + ((m_last + 1) % 16);
            m_state = 0;
          end else m_cnt++;
        end
      endcase
    end
  end

  // Per-clock comparison, after the inputs driven at the falling edge settle.
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk("R6 busy", int'(busy), int'(m_state == 2));
      chk("R1 wr_ready", int'(wr_ready), int'(m_state == 1 && !txn_start && !txn_stop));
      chk("R2 ack_valid", int'(ack_valid), int'(m_ackv));
      if (m_ackv) chk("R7/R8 ack_ok", int'(ack_ok), int'(m_ackok));
      chk("R10 addr_ptr", int'(addr_ptr), m_ptr);
      if (m_rdchk) chk("R11 rd_data", int'(rd_data), m_rd);
    end
  end

  // ---------------- stimulus tasks (entered at a falling edge) ----------------
  task automatic open_txn(input int a);
    txn_start = 1; txn_addr = AW'(a);
    @(negedge clk); txn_start = 0;
  endtask

  task automatic send(input int d, input int exp_ok, input string req);
    wr_valid = 1; wr_data = DW'(d);
    @(negedge clk); wr_valid = 0;
    chk(req, int'(ack_valid), 1);
    chk(req, int'(ack_ok), exp_ok);
  endtask

  task automatic close_txn(input bit partial, input int exp_len, input string req);
    int n;
    txn_stop = 1; stop_partial = partial;
    @(negedge clk); txn_stop = 0; stop_partial = 0;
    n = 0;
    while (busy && n < 4 * WR) begin n++; @(negedge clk); end
    chk(req, n, exp_len);
  endtask

  task automatic rd(input int a, output int v);
    rd_en = 1; rd_addr = AW'(a);
    @(negedge clk); rd_en = 0;
    v = int'(rd_data);
  endtask

  task automatic expect_byte(input int a, input int exp, input string req);
    int v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  int exp_pg [16];

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 busy", int'(busy), 0);
    chk("R12 wr_ready", int'(wr_ready), 0);
    chk("R12 ack_valid", int'(ack_valid), 0);
    chk("R12 addr_ptr", int'(addr_ptr), 0);

    // Single byte write
    open_txn('h005); send('hA5, 1, "R8 byte ack"); close_txn(0, WR, "R6 busy length");
    expect_byte('h005, 'hA5, "R11 byte readback");
    chk("R10 ptr after byte", int'(addr_ptr), 'h006);

    // Full page from mid-page: wraps to page start (R3)
    open_txn('h03A);
    for (int i = 0; i < 16; i++) send('h10 + i, 1, "R8 page ack");
    close_txn(0, WR, "R6 page busy");
    for (int i = 0; i < 16; i++)
      expect_byte('h030 + ((10 + i) % 16), 'h10 + i, "R3 wrap placement");
    chk("R10 ptr after wrap", int'(addr_ptr), 'h03A);

    // 20 bytes: overwrite of earliest slots (R3)
    open_txn('h041);
    for (int i = 0; i < 20; i++) begin
      send('h60 + i, 1, "R8 overrun ack");
      exp_pg[(1 + i) % 16] = 'h60 + i;
    end
    close_txn(0, WR, "R6 overrun busy");
    for (int s = 0; s < 16; s++) expect_byte('h040 + s, exp_pg[s], "R3 overwrite");
    chk("R10 ptr after overrun", int'(addr_ptr), 'h045);

    // Partial page keeps neighbours (R4), with back-pressure gaps
    open_txn('h070);
    for (int i = 0; i < 16; i++) send('h80 + i, 1, "R8 prefill");
    close_txn(0, WR, "R6 prefill busy");
    open_txn('h07E);
    send('hC1, 1, "R8 partial"); @(negedge clk);
    send('hC2, 1, "R8 partial"); @(negedge clk); @(negedge clk);
    send('hC3, 1, "R8 partial");
    close_txn(0, WR, "R6 partial busy");
    expect_byte('h07E, 'hC1, "R4 written slot");
    expect_byte('h07F, 'hC2, "R4 written slot");
    expect_byte('h070, 'hC3, "R4 wrapped slot");
    expect_byte('h07D, 'h8D, "R4 neighbour kept");
    expect_byte('h071, 'h81, "R4 neighbour kept");
    chk("R10 ptr partial", int'(addr_ptr), 'h071);

    // Upper half writable with lock low (R8), refused with lock high (R7)
    open_txn('h150); send('h33, 1, "R8 upper open"); close_txn(0, WR, "R8 upper busy");
    expect_byte('h150, 'h33, "R8 upper written");
    write_lock = 1;
    open_txn('h150); send('h44, 0, "R7 nack"); send('h45, 0, "R7 nack");
    close_txn(0, 0, "R7 no cycle");
    expect_byte('h150, 'h33, "R7 content kept");
    expect_byte('h151, 'h33 - 'h33 + m_mem['h151], "R7 neighbour");
    chk("R7 ptr kept", int'(addr_ptr), 'h151);
    // Lower half still writable under lock (R8)
    open_txn('h0A0); send('h55, 1, "R8 lower locked"); close_txn(0, WR, "R8 lower busy");
    expect_byte('h0A0, 'h55, "R8 lower written");
    write_lock = 0;

    // Lock raised mid-transaction cancels the whole write (R7)
    open_txn('h1F0); send('h66, 1, "R8 before lock");
    write_lock = 1; send('h67, 0, "R7 mid lock");
    write_lock = 0; close_txn(0, 0, "R7 cancelled");

    // Empty stop and torn stop (R9)
    open_txn('h010); close_txn(0, 0, "R9 empty stop");
    open_txn('h020); send('h99, 1, "R8 torn"); close_txn(1, 0, "R9 torn stop");
    chk("R9 ptr kept", int'(addr_ptr), 'h0A1);

    // Old data visible until stop (R5)
    open_txn('h005); send('h5A, 1, "R8 late");
    expect_byte('h005, 'hA5, "R5 no early write");
    close_txn(0, WR, "R5 busy");
    expect_byte('h005, 'h5A, "R5 written after stop");

    // Start and data during busy are ignored (R1)
    open_txn('h0B0); send('h11, 1, "R8 pre busy");
    txn_stop = 1; @(negedge clk); txn_stop = 0;
    repeat (3) @(negedge clk);
    chk("R1 busy seen", int'(busy), 1);
    txn_start = 1; txn_addr = AW'('h0C0); wr_valid = 1; wr_data = 'hEE;
    @(negedge clk); txn_start = 0;
    repeat (3) @(negedge clk);
    chk("R1 ready low in busy", int'(wr_ready), 0);
    wr_valid = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R1 start ignored", int'(wr_ready), 0);
    chk("R10 ptr after busy", int'(addr_ptr), 'h0B1);
    expect_byte('h0B0, 'h11, "R11 readback");

    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule